// File: doc/BRIEF.md
# Flash Sector Program/Erase Guard

This block decides whether a program or erase aimed at one flash sector must be refused because software has marked that sector as locked. A request names the target with a one-hot bank select, a one-hot region select and a bank-relative byte address. Sectors are 2 KB, so the sector number is the address with its low 11 bits dropped. Five lock masks are inputs. The first gives one lock bit to each of the first 32 main-region sectors. The second has 28 bits, and each bit locks a run of eight main-region sectors. The other three masks give one bit to each sector of the non-main, trim and engineering regions.

The two main-region masks combine differently depending on the bank. In bank 0 the per-sector mask locks sectors 0 to 31, and the low four group bits are not used. In every other bank the per-sector mask is ignored, and group bit n covers sectors 8n to 8n+7 starting from sector 0. For a bank erase, the block also gives the full set of main-region sectors in the requested bank that may be erased. Each result is registered and appears one cycle after the request strobe. It stays on the outputs until the next request.

Top module: `fw_sector_guard`

## Requirements
- R1: After reset, rsp_valid, rsp_protected and rsp_illegal are 0, and erase_ok is all zeros.
- R2: rsp_valid is 1 in exactly the cycle after a cycle with req_valid high. The result outputs change only on a request, and they hold their values while req_valid is low, even when other inputs change.
- R3: For a main-region request to bank 0 (bank_id bit 0) at sector s < 32, rsp_protected equals prot_sector[s].
- R4: For bank 0, prot_group bits 3:0 have no effect. Sectors 0–31 with a clear per-sector bit are unprotected even when those group bits are set.
- R5: For bank 0, a main sector s from 32 to 223 is protected exactly when prot_group[s/8] is 1.
- R6: For any bank other than bank 0, prot_sector has no effect. Main sector s < 224 is protected exactly when prot_group[s/8] is 1.
- R7: Main sectors 224 and above are not covered by either main mask, so they are never reported as protected.
- R8: Region select 4'b0010 (non-main), 4'b0100 (trim) and 4'b1000 (engineering) report bit s of prot_nonmain, prot_trim or prot_engr. Region select 4'b0001 is main.
- R9: The sector index is bank_addr[19:11]. Each region has a size: main 256, non-main 4, trim 2, engineering 2. An index at or above the size of the selected region gives rsp_illegal = 1 and rsp_protected = 0.
- R10: If region_id or bank_id does not have exactly one bit set, the result is rsp_illegal = 1 and rsp_protected = 0.
- R11: erase_ok[s] is 1 exactly when main sector s of the requested bank is unprotected under R3–R7. It is computed whatever the region and address are, and it is all zeros when bank_id does not have exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| bank_id | input | 5 | One-hot bank select |
| region_id | input | 4 | One-hot region select |
| bank_addr | input | 20 | Bank-relative byte address |
| prot_sector | input | 32 | Per-sector lock mask for main sectors 0–31 |
| prot_group | input | 28 | Lock mask in groups of eight main sectors |
| prot_nonmain | input | 32 | Per-sector lock mask for the non-main region |
| prot_trim | input | 32 | Per-sector lock mask for the trim region |
| prot_engr | input | 32 | Per-sector lock mask for the engineering region |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_protected | output | 1 | The addressed sector is locked |
| rsp_illegal | output | 1 | The address or selects are invalid |
| erase_ok | output | 256 | Main-region sectors of the bank that may be erased |

## Verification
Two results are produced in the same cycle: the verdict for the addressed sector and the erase map for the whole bank. They can disagree about validity. The bench sends a main-region request with an out-of-range index, and a request with a non-main region whose address is illegal. It expects rsp_illegal to be set while erase_ok still carries the full map for the bank. Requests are also sent back to back, so each response must match its own request and not the one before it.

// File: rtl/fw_prot_pkg.sv
package fw_prot_pkg;
    localparam int SECTOR_SHIFT   = 11;
    localparam int SEC_MASK_W     = 32;
    localparam int GRP_MASK_W     = 28;
    localparam int GRP_SHIFT      = 3;
    localparam int BANK0_SKIP_GRP = SEC_MASK_W >> GRP_SHIFT;

    localparam logic [3:0] REGION_MAIN    = 4'b0001;
    localparam logic [3:0] REGION_NONMAIN = 4'b0010;
    localparam logic [3:0] REGION_TRIM    = 4'b0100;
    localparam logic [3:0] REGION_ENGR    = 4'b1000;
endpackage

// File: rtl/prot_sector_index.sv
module prot_sector_index
    import fw_prot_pkg::*;
#(
    parameter int NUM_BANKS       = 5,
    parameter int ADDR_W          = 20,
    parameter int MAIN_SECTORS    = 256,
    parameter int NONMAIN_SECTORS = 4,
    parameter int TRIM_SECTORS    = 2,
    parameter int ENGR_SECTORS    = 2,
    localparam int IDX_W          = ADDR_W - SECTOR_SHIFT
) (
    input  logic [NUM_BANKS-1:0] bank_id,
    input  logic [3:0]           region_id,
    input  logic [ADDR_W-1:0]    bank_addr,
    output logic [IDX_W-1:0]     sec_idx,
    output logic                 bank_ok,
    output logic                 req_illegal
);
    logic unused_low_bits;
    logic region_ok;
    logic range_bad;

    assign unused_low_bits = ^bank_addr[SECTOR_SHIFT-1:0];
    assign sec_idx         = bank_addr[ADDR_W-1:SECTOR_SHIFT];

    assign bank_ok   = (bank_id != '0) && ((bank_id & (bank_id - 1'b1)) == '0);
    assign region_ok = (region_id != '0) && ((region_id & (region_id - 1'b1)) == '0);

    always_comb begin
        range_bad = 1'b1;
        unique case (region_id)
            REGION_MAIN:    range_bad = (int'(sec_idx) >= MAIN_SECTORS);
            REGION_NONMAIN: range_bad = (int'(sec_idx) >= NONMAIN_SECTORS);
            REGION_TRIM:    range_bad = (int'(sec_idx) >= TRIM_SECTORS);
            REGION_ENGR:    range_bad = (int'(sec_idx) >= ENGR_SECTORS);
            default:        range_bad = 1'b1;
        endcase
    end

    assign req_illegal = !bank_ok || !region_ok || range_bad;
endmodule

// File: rtl/prot_main_map.sv
module prot_main_map
    import fw_prot_pkg::*;
#(
    parameter int MAIN_SECTORS = 256
) (
    input  logic                    is_bank0,
    input  logic [SEC_MASK_W-1:0]   prot_sector,
    input  logic [GRP_MASK_W-1:0]   prot_group,
    output logic [MAIN_SECTORS-1:0] locked_vec
);
    for (genvar s = 0; s < MAIN_SECTORS; s++) begin : g_sec
        localparam int GRP = s >> GRP_SHIFT;
        if (s < SEC_MASK_W) begin : g_low
            // bank 0 takes the per-sector bit; other banks fall back to the group bit
            assign locked_vec[s] = is_bank0 ? prot_sector[s] : prot_group[GRP];
        end else if (GRP < GRP_MASK_W) begin : g_grp
            assign locked_vec[s] = prot_group[GRP];
        end else begin : g_free
            assign locked_vec[s] = 1'b0;
        end
    end
endmodule

// File: rtl/prot_region_mux.sv
module prot_region_mux
    import fw_prot_pkg::*;
#(
    parameter int MAIN_SECTORS = 256,
    parameter int IDX_W        = 9,
    localparam int IDX_SPAN    = 1 << IDX_W,
    localparam int SMALL_W     = $clog2(SEC_MASK_W)
) (
    input  logic [3:0]              region_id,
    input  logic [IDX_W-1:0]        sec_idx,
    input  logic [MAIN_SECTORS-1:0] main_locked,
    input  logic [SEC_MASK_W-1:0]   prot_nonmain,
    input  logic [SEC_MASK_W-1:0]   prot_trim,
    input  logic [SEC_MASK_W-1:0]   prot_engr,
    output logic                    locked
);
    logic [IDX_SPAN-1:0] main_pad;
    logic [SMALL_W-1:0]  small_idx;

    assign main_pad  = IDX_SPAN'(main_locked);
    assign small_idx = sec_idx[SMALL_W-1:0];

    always_comb begin
        locked = 1'b0;
        unique case (region_id)
            REGION_MAIN:    locked = main_pad[sec_idx];
            REGION_NONMAIN: locked = prot_nonmain[small_idx];
            REGION_TRIM:    locked = prot_trim[small_idx];
            REGION_ENGR:    locked = prot_engr[small_idx];
            default:        locked = 1'b0;
        endcase
    end
endmodule

// File: rtl/fw_sector_guard.sv
module fw_sector_guard
    import fw_prot_pkg::*;
#(
    parameter int NUM_BANKS       = 5,
    parameter int ADDR_W          = 20,
    parameter int MAIN_SECTORS    = 256,
    parameter int NONMAIN_SECTORS = 4,
    parameter int TRIM_SECTORS    = 2,
    parameter int ENGR_SECTORS    = 2,
    localparam int IDX_W          = ADDR_W - SECTOR_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [NUM_BANKS-1:0]    bank_id,
    input  logic [3:0]              region_id,
    input  logic [ADDR_W-1:0]       bank_addr,
    input  logic [SEC_MASK_W-1:0]   prot_sector,
    input  logic [GRP_MASK_W-1:0]   prot_group,
    input  logic [SEC_MASK_W-1:0]   prot_nonmain,
    input  logic [SEC_MASK_W-1:0]   prot_trim,
    input  logic [SEC_MASK_W-1:0]   prot_engr,
    output logic                    rsp_valid,
    output logic                    rsp_protected,
    output logic                    rsp_illegal,
    output logic [MAIN_SECTORS-1:0] erase_ok
);
    typedef struct packed {
        logic                    valid;
        logic                    locked;
        logic                    illegal;
        logic [MAIN_SECTORS-1:0] erase;
    } guard_state_t;

    guard_state_t st_d, st_q;

    logic [IDX_W-1:0]        sec_idx;
    logic                    bank_ok;
    logic                    req_illegal;
    logic [MAIN_SECTORS-1:0] main_locked;
    logic                    sel_locked;

    prot_sector_index #(
        .NUM_BANKS      (NUM_BANKS),
        .ADDR_W         (ADDR_W),
        .MAIN_SECTORS   (MAIN_SECTORS),
        .NONMAIN_SECTORS(NONMAIN_SECTORS),
        .TRIM_SECTORS   (TRIM_SECTORS),
        .ENGR_SECTORS   (ENGR_SECTORS)
    ) u_index (
        .bank_id    (bank_id),
        .region_id  (region_id),
        .bank_addr  (bank_addr),
        .sec_idx    (sec_idx),
        .bank_ok    (bank_ok),
        .req_illegal(req_illegal)
    );

    prot_main_map #(
        .MAIN_SECTORS(MAIN_SECTORS)
    ) u_map (
        .is_bank0   (bank_id[0]),
        .prot_sector(prot_sector),
        .prot_group (prot_group),
        .locked_vec (main_locked)
    );

    prot_region_mux #(
        .MAIN_SECTORS(MAIN_SECTORS),
        .IDX_W       (IDX_W)
    ) u_mux (
        .region_id   (region_id),
        .sec_idx     (sec_idx),
        .main_locked (main_locked),
        .prot_nonmain(prot_nonmain),
        .prot_trim   (prot_trim),
        .prot_engr   (prot_engr),
        .locked      (sel_locked)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.illegal = req_illegal;
            st_d.locked  = !req_illegal && sel_locked;
            st_d.erase   = bank_ok ? ~main_locked : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.valid;
    assign rsp_protected = st_q.locked;
    assign rsp_illegal   = st_q.illegal;
    assign erase_ok      = st_q.erase;

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_protected)
                        && $stable(rsp_illegal) && $stable(erase_ok)));

    // R9
    excl_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_protected && rsp_illegal));

    // R10
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (($countones(region_id) != 1) || ($countones(bank_id) != 1)))
        |=> rsp_illegal);

    // R11
    erase_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (bank_id == '0)) |=> (erase_ok == '0));
endmodule

// File: tb/fw_sector_guard_test.sv
`timescale 1ns/1ps
module fw_sector_guard_test;
    localparam int NSEC = 256;

    typedef struct {
        logic            prot;
        logic            ill;
        logic [NSEC-1:0] er;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [4:0]      bank_id = '0;
    logic [3:0]      region_id = '0;
    logic [19:0]     bank_addr = '0;
    logic [31:0]     prot_sector = '0;
    logic [27:0]     prot_group = '0;
    logic [31:0]     prot_nonmain = '0;
    logic [31:0]     prot_trim = '0;
    logic [31:0]     prot_engr = '0;
    logic            rsp_valid, rsp_protected, rsp_illegal;
    logic [NSEC-1:0] erase_ok;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t q[$];
    exp_t last;

    always #2.5 clk = ~clk;

    fw_sector_guard uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bank_id(bank_id),
        .region_id(region_id), .bank_addr(bank_addr), .prot_sector(prot_sector),
        .prot_group(prot_group), .prot_nonmain(prot_nonmain), .prot_trim(prot_trim),
        .prot_engr(prot_engr), .rsp_valid(rsp_valid), .rsp_protected(rsp_protected),
        .rsp_illegal(rsp_illegal), .erase_ok(erase_ok)
    );

    task automatic check(string tag, logic [NSEC-1:0] act, logic [NSEC-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit one_hot(logic [4:0] v);
        return $countones(v) == 1;
    endfunction

    // model of R3-R7
    function automatic logic main_locked(logic b0, int s);
        if (b0 && s < 32) return prot_sector[s];
        if (s / 8 >= 28) return 1'b0;
        return prot_group[s / 8];
    endfunction

    task automatic send(logic [4:0] bank, logic [3:0] region, int idx, string tag);
        exp_t e;
        int   size;
        logic sel;
        @(negedge clk);
        case (region)
            4'b0001: begin size = 256; sel = (idx < 256) ? main_locked(bank[0], idx) : 1'b0; end
            4'b0010: begin size = 4;   sel = prot_nonmain[idx % 32]; end
            4'b0100: begin size = 2;   sel = prot_trim[idx % 32]; end
            4'b1000: begin size = 2;   sel = prot_engr[idx % 32]; end
            default: begin size = 0;   sel = 1'b0; end
        endcase
        e.ill  = !one_hot(bank) || !one_hot({1'b0, region}) || (idx >= size);
        e.prot = !e.ill && sel;
        for (int s = 0; s < NSEC; s++)
            e.er[s] = one_hot(bank) ? !main_locked(bank[0], s) : 1'b0;
        e.tag = tag;
        q.push_back(e);
        last = e;
        bank_id   = bank;
        region_id = region;
        bank_addr = 20'(idx << 11) | 20'h2a5;
        req_valid = 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                check("R2 unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " protected"}, NSEC'(rsp_protected), NSEC'(e.prot));
                check({e.tag, " illegal"}, NSEC'(rsp_illegal), NSEC'(e.ill));
                check({e.tag, " R11 erase_ok"}, erase_ok, e.er);
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rsp_valid", NSEC'(rsp_valid), 0);
        check("R1 rsp_protected", NSEC'(rsp_protected), 0);
        check("R1 rsp_illegal", NSEC'(rsp_illegal), 0);
        check("R1 erase_ok", erase_ok, '0);
        rst_n = 1'b1;
        idle(2);

        prot_sector  = 32'h0000_0020;
        prot_group   = 28'h0F0_002F;
        prot_nonmain = 32'h0000_0004;
        prot_trim    = 32'h0000_0002;
        prot_engr    = 32'h0000_0001;

        // back-to-back stream
        send(5'b00001, 4'b0001, 5,   "R3 bank0 sec5");
        send(5'b00001, 4'b0001, 6,   "R4 bank0 sec6 grp ignored");
        send(5'b00001, 4'b0001, 40,  "R5 bank0 sec40");
        send(5'b00001, 4'b0001, 48,  "R5 bank0 sec48");
        send(5'b00100, 4'b0001, 5,   "R6 bank2 sec5");
        send(5'b00100, 4'b0001, 9,   "R6 bank2 sec9");
        send(5'b00010, 4'b0001, 30,  "R6 bank1 sec30");
        idle(2);

        prot_group = 28'hFFF_FFFF;
        send(5'b00001, 4'b0001, 230, "R7 bank0 sec230");
        send(5'b00010, 4'b0001, 250, "R7 bank1 sec250");
        send(5'b10000, 4'b0001, 223, "R6 bank4 sec223");
        idle(1);

        prot_group = 28'h0F0_002F;
        send(5'b00001, 4'b0010, 2,   "R8 nonmain sec2");
        send(5'b00001, 4'b0010, 3,   "R8 nonmain sec3");
        send(5'b00010, 4'b0100, 1,   "R8 trim sec1");
        send(5'b01000, 4'b1000, 0,   "R8 engr sec0");
        idle(1);

        send(5'b00001, 4'b0001, 300, "R9 main idx300");
        send(5'b00010, 4'b0010, 4,   "R9 nonmain idx4");
        send(5'b00001, 4'b0100, 2,   "R9 trim idx2");
        send(5'b00001, 4'b1000, 5,   "R9 engr idx5");
        send(5'b00001, 4'b0011, 1,   "R10 region two bits");
        send(5'b00001, 4'b0000, 1,   "R10 region none");
        send(5'b00000, 4'b0001, 1,   "R10 bank none");
        send(5'b00011, 4'b0001, 1,   "R10 bank two bits");
        send(5'b00001, 4'b0001, 5,   "R3 bank0 sec5 after illegal");
        idle(1);

        // hold while idle with changed inputs
        prot_sector  = 32'h0;
        prot_group   = 28'h0;
        bank_id      = 5'b00100;
        region_id    = 4'b0010;
        bank_addr    = 20'h0;
        idle(3);
        check("R2 held rsp_valid", NSEC'(rsp_valid), 0);
        check("R2 held protected", NSEC'(rsp_protected), NSEC'(last.prot));
        check("R2 held illegal", NSEC'(rsp_illegal), NSEC'(last.ill));
        check("R2 held erase_ok", erase_ok, last.er);
        check("R2 all responses seen", NSEC'(q.size()), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule